// File: doc/BRIEF.md
# Flash buffered-program command sequencer

This block is the device-side command state machine for buffered word programming in a parallel NOR flash model. A host writes an address and a 16-bit data word on each bus cycle. A program transfer takes these writes, in order: a setup command, a word count, the start address with the first data word, any further data words, and a confirm command. The words are collected in a write buffer. After a valid confirm, the block streams the buffer to a behavioural array model, one word per strobe.

An 8-bit status byte reports four things: the ready flag, a sequence-error flag, a program-error flag and a supply-lockout flag. Malformed transfers are aborted, and each kind of failure sets its own combination of flags. The kinds are a bad protocol step, an address outside the declared range, a transfer that would run over the end of an erase block, a failure reported by the array, and a setup attempt while the programming supply is below lockout. The error flags are sticky until the host writes a clear command.

A transfer whose range crosses a buffer-sized address line takes twice as long to commit as one that stays inside a line.

Top module: `fbp_seq`

## Requirements
- R1: After reset the status byte reads 0x80 and `pgm_we` is low.
- R2: While idle, a write of data 0x00E8 with `vpp_low` low starts a transfer, and the setup address selects the erase block. The next write carries the word count minus one in `wr_data`. A value above BUF_WORDS-1 is a sequence error that sets status bits 5 and 4, and the block returns to idle. A value of 0 means a single word.
- R3: The third write gives the start address and the word for buffer index 0. Each later data write must address start+i with 0 <= i <= count and stores to index i. Another address aborts with status bits 5 and 4. A repeated index keeps the last word written.
- R4: If the start address lies outside the setup erase block, or start offset within the block plus the count reaches BLOCK_WORDS, the transfer aborts with status bits 5 and 4.
- R5: After the last data word, only data 0x00D0 written to an address in the setup erase block begins programming. Any other write in that slot aborts with status bits 7, 5 and 4 set.
- R6: While programming, status bit 7 reads 0 and all bus writes are ignored. Word i is presented once on `pgm_addr` = start+i and `pgm_data`, with `pgm_we` high, in increasing i. An index not written in this transfer presents 0xFFFF. Status bit 7 returns to 1 after the last word.
- R7: When (start mod BUF_WORDS) + count <= BUF_WORDS-1, one word is committed per cycle, so programming lasts count+1 cycles. Otherwise one word is committed every second cycle, and programming lasts 2*(count+1) cycles.
- R8: If `arr_fail` is high in a cycle with `pgm_we` high, programming stops at once. Status bits 7 and 4 are set, and no further `pgm_we` follows.
- R9: A setup write (0x00E8) while idle with `vpp_low` high sets status bits 4 and 3 and starts no transfer. The next write is treated as an idle write.
- R10: While idle, a write of 0x0050 clears status bits 5, 4 and 3. These bits otherwise stay set, and other idle writes change nothing.
- R11: Status bits 6, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host bus write strobe, one write per cycle high |
| wr_addr | input | ADDR_W | Word address of the host write |
| wr_data | input | 16 | Command, count or data word of the host write |
| vpp_low | input | 1 | Programming supply below lockout level |
| arr_fail | input | 1 | Array model reports failure of the word being committed |
| sr | output | 8 | Status byte: bit 7 ready, 5 sequence error, 4 program error, 3 supply lockout |
| pgm_we | output | 1 | Commit strobe for one buffered word |
| pgm_addr | output | ADDR_W | Array address of the committed word |
| pgm_data | output | 16 | Data of the committed word |

## Verification
The bench builds the block with ADDR_W=12, BLOCK_WORDS=64 and BUF_WORDS=32. The small erase block puts block edges a few dozen addresses apart. Overrun aborts, confirms aimed at a neighbouring block, and starts placed near a line edge are therefore all reachable with short address values. A full 32-word buffer still fits inside one block. Both commit paces and the single-word and maximum counts are driven, and the outputs are compared against a behavioural model on every cycle.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] CMD_SETUP   = 16'h00E8;
  localparam logic [DATA_W-1:0] CMD_CONFIRM = 16'h00D0;
  localparam logic [DATA_W-1:0] CMD_CLEAR   = 16'h0050;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COUNT,
    S_FIRST,
    S_DATA,
    S_CONFIRM,
    S_PROG
  } seq_state_t;

  // A range of cnt+1 words starting at offset off stays below lim.
  function automatic logic fits_span(input int unsigned off,
                                     input int unsigned cnt,
                                     input int unsigned lim);
    return (off + cnt) < lim;
  endfunction

  // A range of cnt+1 words starting at line offset off spills into the next line.
  function automatic logic crosses_line(input int unsigned off,
                                        input int unsigned cnt,
                                        input int unsigned line);
    return (off + cnt) > (line - 1);
  endfunction

endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int BUF_WORDS = 32,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [BUF_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) mem_q[i] <= '1;
    end else if (fill) begin
      for (int i = 0; i < BUF_WORDS; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];

endmodule

// File: rtl/fbp_addr_chk.sv
module fbp_addr_chk #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_WORDS = 1024,
  parameter int BUF_WORDS   = 32,
  localparam int CNT_W      = $clog2(BUF_WORDS),
  localparam int BLK_W      = $clog2(BLOCK_WORDS),
  localparam int LINE_W     = $clog2(BUF_WORDS),
  localparam int BNUM_W     = ADDR_W - BLK_W
) (
  input  logic [BNUM_W-1:0] blk_num,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic              same_blk,
  output logic              span_ok,
  output logic              win_ok,
  output logic [CNT_W-1:0]  win_idx,
  output logic              line_cross
);

  logic [ADDR_W-1:0] offs;

  assign same_blk   = (cur_addr[ADDR_W-1:BLK_W] == blk_num);
  assign span_ok    = same_blk &&
                      fbp_pkg::fits_span(32'(cur_addr[BLK_W-1:0]), 32'(cnt), BLOCK_WORDS);
  assign offs       = cur_addr - start_addr;
  assign win_ok     = (offs <= ADDR_W'(cnt));
  assign win_idx    = offs[CNT_W-1:0];
  assign line_cross = fbp_pkg::crosses_line(32'(cur_addr[LINE_W-1:0]), 32'(cnt), BUF_WORDS);

endmodule

// File: rtl/fbp_prog_eng.sv
module fbp_prog_eng #(
  parameter int ADDR_W    = 16,
  parameter int BUF_WORDS = 32,
  localparam int CNT_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              slow,
  input  logic              arr_fail,
  output logic              busy,
  output logic              pgm_we,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              done_evt,
  output logic              fail_evt
);

  logic             busy_q;
  logic             phase_q;
  logic [CNT_W-1:0] idx_q;

  assign busy     = busy_q;
  assign pgm_we   = busy_q && (!slow || phase_q);
  assign pgm_addr = start_addr + ADDR_W'(idx_q);
  assign rd_idx   = idx_q;
  assign fail_evt = pgm_we && arr_fail;
  assign done_evt = pgm_we && !arr_fail && (idx_q == cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (go) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (busy_q) begin
      if (fail_evt || done_evt) begin
        busy_q <= 1'b0;
      end else if (pgm_we) begin
        idx_q   <= idx_q + 1'b1;
        phase_q <= 1'b0;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end

  // R7: on the doubled pace a strobe is always followed by a gap cycle
  p_pace_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_we && slow && !fail_evt && !done_evt) |=> !pgm_we);

  // R8: a reported array failure ends the commit on the next cycle
  p_fail_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (!busy && !pgm_we));

  // R6: the engine only strobes while a commit is running
  p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_we |-> busy);

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_WORDS = 1024,
  parameter int BUF_WORDS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              vpp_low,
  input  logic              arr_fail,
  output logic [7:0]        sr,
  output logic              pgm_we,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [15:0]       pgm_data
);

  localparam int CNT_W  = $clog2(BUF_WORDS);
  localparam int BLK_W  = $clog2(BLOCK_WORDS);
  localparam int BNUM_W = ADDR_W - BLK_W;

  seq_state_t        state_q;
  logic [BNUM_W-1:0] blk_q;
  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rem_q;
  logic              slow_q;
  logic              err_seq_q, err_prog_q, err_vpp_q;

  // Named events for the assertions
  logic idle_wr, setup_evt, vpp_evt, clr_evt, seq_err_evt, go_evt;
  logic cnt_bad, confirm_ok;
  logic buf_we;
  logic [CNT_W-1:0] buf_widx;

  logic             same_blk, span_ok, win_ok, line_cross;
  logic [CNT_W-1:0] win_idx;
  logic             eng_busy, eng_done, eng_fail;
  logic [CNT_W-1:0] rd_idx;

  fbp_addr_chk #(
    .ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS), .BUF_WORDS(BUF_WORDS)
  ) u_chk (
    .blk_num   (blk_q),
    .cur_addr  (wr_addr),
    .start_addr(start_q),
    .cnt       (cnt_q),
    .same_blk  (same_blk),
    .span_ok   (span_ok),
    .win_ok    (win_ok),
    .win_idx   (win_idx),
    .line_cross(line_cross)
  );

  assign idle_wr    = wr_en && (state_q == S_IDLE);
  assign setup_evt  = idle_wr && (wr_data == CMD_SETUP) && !vpp_low;
  assign vpp_evt    = idle_wr && (wr_data == CMD_SETUP) && vpp_low;
  assign clr_evt    = idle_wr && (wr_data == CMD_CLEAR);
  assign cnt_bad    = (wr_data > 16'(BUF_WORDS - 1));
  assign confirm_ok = (wr_data == CMD_CONFIRM) && same_blk;
  assign go_evt     = wr_en && (state_q == S_CONFIRM) && confirm_ok;

  always_comb begin
    seq_err_evt = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        S_COUNT:   seq_err_evt = cnt_bad;
        S_FIRST:   seq_err_evt = !span_ok;
        S_DATA:    seq_err_evt = !win_ok;
        S_CONFIRM: seq_err_evt = !confirm_ok;
        default:   seq_err_evt = 1'b0;
      endcase
    end
  end

  assign buf_we   = wr_en && (((state_q == S_FIRST) && span_ok) ||
                              ((state_q == S_DATA) && win_ok));
  assign buf_widx = (state_q == S_FIRST) ? '0 : win_idx;

  fbp_wbuf #(.BUF_WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .fill (setup_evt),
    .we   (buf_we),
    .widx (buf_widx),
    .wdata(wr_data),
    .ridx (rd_idx),
    .rdata(pgm_data)
  );

  fbp_prog_eng #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_evt),
    .start_addr(start_q),
    .cnt       (cnt_q),
    .slow      (slow_q),
    .arr_fail  (arr_fail),
    .busy      (eng_busy),
    .pgm_we    (pgm_we),
    .pgm_addr  (pgm_addr),
    .rd_idx    (rd_idx),
    .done_evt  (eng_done),
    .fail_evt  (eng_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      slow_q  <= 1'b0;
    end else if (seq_err_evt) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (setup_evt) begin
          state_q <= S_COUNT;
          blk_q   <= wr_addr[ADDR_W-1:BLK_W];
        end
        S_COUNT: if (wr_en) begin
          cnt_q   <= wr_data[CNT_W-1:0];
          state_q <= S_FIRST;
        end
        S_FIRST: if (wr_en) begin
          start_q <= wr_addr;
          rem_q   <= cnt_q;
          slow_q  <= line_cross;
          state_q <= (cnt_q == '0) ? S_CONFIRM : S_DATA;
        end
        S_DATA: if (wr_en) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) state_q <= S_CONFIRM;
        end
        S_CONFIRM: if (go_evt) state_q <= S_PROG;
        S_PROG: if (eng_done || eng_fail) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_seq_q  <= 1'b0;
      err_prog_q <= 1'b0;
      err_vpp_q  <= 1'b0;
    end else if (clr_evt) begin
      err_seq_q  <= 1'b0;
      err_prog_q <= 1'b0;
      err_vpp_q  <= 1'b0;
    end else begin
      if (seq_err_evt)                        err_seq_q  <= 1'b1;
      if (seq_err_evt || vpp_evt || eng_fail) err_prog_q <= 1'b1;
      if (vpp_evt)                            err_vpp_q  <= 1'b1;
    end
  end

  assign sr = {state_q != S_PROG, 1'b0, err_seq_q, err_prog_q, err_vpp_q, 3'b000};

  // R5: a sequence error leaves the block ready with bits 5 and 4 raised
  p_seq_err_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_evt |=> (sr[7] && sr[5] && sr[4]));

  // R9: a refused setup raises bits 4 and 3 and starts nothing
  p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_evt |=> (sr[4] && sr[3] && state_q == S_IDLE));

  // R10: error flags are sticky without a clear command
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[5] && !clr_evt) |=> sr[5]);

  // R6: a commit strobe is only seen while ready reads 0
  p_busy_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_we |-> !sr[7]);

  // R6: the sequencer and the engine agree on when programming runs
  p_state_engine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG) == eng_busy);

  // R11: the unused status bits stay low
  p_spare_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[6] == 1'b0) && (sr[2:0] == 3'b000));

endmodule

// File: tb/fbp_seq_tb.sv
module fbp_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int BW  = 64;
  localparam int BUF = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          vpp_low = 1'b0;
  logic          arr_fail = 1'b0;
  logic [7:0]    sr;
  logic          pgm_we;
  logic [AW-1:0] pgm_addr;
  logic [15:0]   pgm_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbp_seq #(.ADDR_W(AW), .BLOCK_WORDS(BW), .BUF_WORDS(BUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_low(vpp_low), .arr_fail(arr_fail), .sr(sr), .pgm_we(pgm_we),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;
  int    n_pulse = 0;
  int    n_busy = 0;

  // Behavioural reference: 0 idle, 1 count, 2 first, 3 data, 4 confirm, 5 commit
  int m_st = 0;
  int m_blk, m_start, m_cnt, m_rem, m_tick;
  bit m_slow;
  int m_buf [BUF];
  bit e5, e4, e3;

  function automatic int m_pace();
    return m_slow ? 2 : 1;
  endfunction

  function automatic bit m_we();
    return (m_st == 5) && ((m_tick % m_pace()) == m_pace() - 1);
  endfunction

  task automatic m_abort();
    e5 = 1'b1; e4 = 1'b1; m_st = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; e5 = 0; e4 = 0; e3 = 0;
      foreach (m_buf[i]) m_buf[i] = 16'hFFFF;
    end else if (m_st == 5) begin
      if (m_we() && arr_fail) begin
        e4 = 1'b1; m_st = 0;
      end else if (m_we() && (m_tick / m_pace()) == m_cnt) begin
        m_st = 0;
      end else begin
        m_tick++;
      end
    end else if (wr_en) begin
      int a, d, off;
      a = int'(wr_addr); d = int'(wr_data);
      case (m_st)
        0: begin
          if (d == 'hE8) begin
            if (vpp_low) begin e4 = 1; e3 = 1; end
            else begin
              m_st = 1; m_blk = a / BW;
              foreach (m_buf[i]) m_buf[i] = 16'hFFFF;
            end
          end else if (d == 'h50) begin
            e5 = 0; e4 = 0; e3 = 0;
          end
        end
        1: begin
          if (d > BUF - 1) m_abort();
          else begin m_cnt = d; m_st = 2; end
        end
        2: begin
          if ((a / BW) != m_blk || (a % BW) + m_cnt >= BW) m_abort();
          else begin
            m_start = a; m_buf[0] = d; m_rem = m_cnt;
            m_slow = ((a % BUF) + m_cnt) > BUF - 1;
            m_st = (m_cnt == 0) ? 4 : 3;
          end
        end
        3: begin
          off = a - m_start;
          if (off < 0 || off > m_cnt) m_abort();
          else begin
            m_buf[off] = d; m_rem--;
            if (m_rem == 0) m_st = 4;
          end
        end
        4: begin
          if (d == 'hD0 && (a / BW) == m_blk) begin m_st = 5; m_tick = 0; end
          else m_abort();
        end
        default: m_st = 0;
      endcase
    end
  end

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] exp_sr;
      bit ew;
      exp_sr = {m_st != 5, 1'b0, e5, e4, e3, 3'b000};
      ew = m_we();
      n_vec++;
      if (sr !== exp_sr) begin
        n_bad++;
        $display("FAIL %s status act=%h exp=%h t=%0t", cur_req, sr, exp_sr, $time);
      end
      n_vec++;
      if (pgm_we !== ew) begin
        n_bad++;
        $display("FAIL %s pgm_we act=%b exp=%b t=%0t", cur_req, pgm_we, ew, $time);
      end
      if (ew) begin
        int idx;
        idx = m_tick / m_pace();
        n_vec++;
        if (pgm_addr !== AW'(m_start + idx) || pgm_data !== 16'(m_buf[idx])) begin
          n_bad++;
          $display("FAIL R6 word %0d act=%h/%h exp=%h/%h", idx, pgm_addr, pgm_data,
                   AW'(m_start + idx), 16'(m_buf[idx]));
        end
      end
      if (pgm_we) n_pulse++;
      if (!sr[7]) n_busy++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(0, 'h50);
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired under %s", cur_req);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 / R11: reset state
    cur_req = "R1";
    check("R1 status after reset", int'(sr), 'h80);
    check("R1 no strobe after reset", int'(pgm_we), 0);
    check("R11 spare bits", int'(sr & 8'h47), 0);

    // R6 / R7: aligned 4-word transfer, one index left unwritten, repeated index
    cur_req = "R6";
    wr('h040, 'hE8); wr('h040, 3); wr('h040, 'hA0A0);
    wr('h043, 'hD3D3); wr('h041, 'h1111); wr('h041, 'hD1D1);
    n_pulse = 0; n_busy = 0;
    wr('h050, 'hD0);
    check("R6 ready low while committing", int'(sr[7]), 0);
    wr('h040, 'hE8);  // ignored while busy
    idle(8);
    check("R6 four strobes", n_pulse, 4);
    check("R7 aligned busy cycles", n_busy, 4);
    check("R6 ready again", int'(sr), 'h80);

    // R7: crossing transfer doubles time
    cur_req = "R7";
    wr('h080, 'hE8); wr('h080, 4); wr('h09E, 'h0001);
    wr('h09F, 'h0002); wr('h0A0, 'h0003); wr('h0A1, 'h0004); wr('h0A2, 'h0005);
    n_pulse = 0; n_busy = 0;
    wr('h080, 'hD0);
    idle(14);
    check("R7 crossing strobes", n_pulse, 5);
    check("R7 crossing busy cycles", n_busy, 10);

    // R7: unaligned, not crossing
    wr('h0C0, 'hE8); wr('h0C0, 2); wr('h0C3, 'h3333); wr('h0C4, 'h4444); wr('h0C5, 'h5555);
    n_pulse = 0; n_busy = 0;
    wr('h0C0, 'hD0);
    idle(6);
    check("R7 unaligned busy cycles", n_busy, 3);

    // R2: single word and full buffer
    cur_req = "R2";
    wr('h100, 'hE8); wr('h100, 0); wr('h13F, 'hBEEF);
    n_pulse = 0;
    wr('h13F, 'hD0);
    idle(4);
    check("R2 single word strobes", n_pulse, 1);
    wr('h140, 'hE8); wr('h140, 31); wr('h140, 0);
    for (int i = 1; i < 32; i++) wr('h140 + i, i * 3);
    n_pulse = 0; n_busy = 0;
    wr('h140, 'hD0);
    idle(36);
    check("R2 full buffer strobes", n_pulse, 32);
    check("R2 full buffer aligned time", n_busy, 32);
    // R2: count too large
    wr('h140, 'hE8); wr('h140, 32);
    check("R2 bad count flags", int'(sr), 'hB0);
    // R10: sticky, then clear
    cur_req = "R10";
    wr('h140, 'h1234);
    check("R10 error sticky", int'(sr), 'hB0);
    clear_all();
    check("R10 cleared", int'(sr), 'h80);

    // R4: block overrun and foreign block start
    cur_req = "R4";
    wr('h040, 'hE8); wr('h040, 10); wr('h07A, 'h7777);
    check("R4 overrun abort", int'(sr), 'hB0);
    clear_all();
    wr('h040, 'hE8); wr('h040, 1); wr('h100, 'h7777);
    check("R4 foreign block abort", int'(sr), 'hB0);
    clear_all();

    // R3: window violations above and below
    cur_req = "R3";
    wr('h000, 'hE8); wr('h000, 2); wr('h010, 'h1); wr('h013, 'h2);
    check("R3 above window", int'(sr), 'hB0);
    clear_all();
    wr('h000, 'hE8); wr('h000, 2); wr('h010, 'h1); wr('h00F, 'h2);
    check("R3 below window", int'(sr), 'hB0);
    clear_all();

    // R5: wrong confirm data and wrong confirm block
    cur_req = "R5";
    n_pulse = 0;
    wr('h000, 'hE8); wr('h000, 0); wr('h005, 'h9); wr('h000, 'hFF);
    check("R5 bad confirm data", int'(sr), 'hB0);
    clear_all();
    wr('h000, 'hE8); wr('h000, 0); wr('h005, 'h9); wr('h040, 'hD0);
    check("R5 confirm to other block", int'(sr), 'hB0);
    idle(3);
    check("R5 nothing committed", n_pulse, 0);
    clear_all();

    // R9: supply lockout
    cur_req = "R9";
    vpp_low = 1'b1;
    wr('h000, 'hE8);
    check("R9 lockout flags", int'(sr), 'h98);
    vpp_low = 1'b0;
    wr('h000, 5);
    check("R9 no transfer started", int'(sr), 'h98);
    clear_all();
    check("R10 clear after lockout", int'(sr), 'h80);

    // R8: failure on first word
    cur_req = "R8";
    wr('h000, 'hE8); wr('h000, 3); wr('h000, 1); wr('h001, 2); wr('h002, 3); wr('h003, 4);
    arr_fail = 1'b1;
    n_pulse = 0;
    wr('h000, 'hD0);
    idle(6);
    arr_fail = 1'b0;
    check("R8 stop after first", n_pulse, 1);
    check("R8 flags", int'(sr), 'h90);
    clear_all();
    // R8: failure on third word of a slow transfer
    wr('h000, 'hE8); wr('h000, 5); wr('h01C, 1);
    for (int i = 1; i <= 5; i++) wr('h01C + i, i + 1);
    n_pulse = 0;
    wr('h000, 'hD0);
    while (n_pulse < 2) @(negedge clk);
    while (!pgm_we) @(negedge clk);
    arr_fail = 1'b1;
    @(negedge clk);
    arr_fail = 1'b0;
    idle(8);
    check("R8 stop after third", n_pulse, 3);
    check("R8 flags mid", int'(sr), 'h90);
    clear_all();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule